// File: doc/BRIEF.md
# Gated Event Interrupt Flag Controller

This block gathers a set of single-cycle event pulses from a peripheral into sticky flag bits and turns them into at most one interrupt pulse toward the CPU-side interrupt expander. Every event has its own enable bit. A flag latches whether or not its event is enabled, so software can poll it with interrupts off. A global pending bit closes the interrupt path once a pulse has gone out. No further pulse can leave until software clears that bit, normally in the same write that clears the event it serviced.

Software reaches the block through one small register port. One write address holds the enable mask. Another takes write-one-to-clear commands, and a third sets event flags as if the events had fired, which is useful for testing. A read of the flag address returns every event flag together with the global bit. The flag vector and the global bit are also available as ports, and the interrupt pulse leaves on its own output.

Top module: `evt_irq_gate`

## Requirements
- R1: After reset, all event flags, the global pending bit, the interrupt pulse and the enable mask are zero.
- R2: Event input i sets flag i, which is read back at bit i+1 of address 1, on the clock edge after it is high, whatever its enable bit holds. The flag stays set until it is cleared.
- R3: Address 0 holds the enable mask. Bit i+1 enables event i, and bit 0 is not stored and reads back as zero.
- R4: When the global bit is clear and some flag with its enable bit set is registered, the next clock edge raises the interrupt pulse and the global bit together. The pulse lasts exactly one cycle.
- R5: A flag whose enable bit is zero never causes an interrupt pulse.
- R6: While the global bit is set, no interrupt pulse is produced, and new events still latch into their flags.
- R7: A write to address 2 clears every flag whose bit is one (bit i+1 for event i), and bit 0 clears the global bit. Zero bits leave their flags unchanged.
- R8: After the global bit is cleared, a pulse follows again as soon as an enabled flag is set. This applies both to a flag that was left pending and to a fresh event that arrives after all flags were cleared.
- R9: A write to address 3 sets event flag i for each one at bit i+1, exactly as an event would. Bit 0 of this write has no effect.
- R10: An event that arrives in the same cycle as a clear of its own flag leaves the flag set.
- R11: A read of address 1 returns the global bit at bit 0 and the event flags at bits 1 to 11. Reads of addresses 2 and 3 return zero.
- R12: Setting the enable bit of a flag that is already latched raises the interrupt pulse one cycle after the enable write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 11 | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| flags_o | output | 11 | Latched event flags |
| gint_o | output | 1 | Global interrupt-pending bit |
| irq_pulse_o | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: eleven events and a 16-bit data word. These values put every event bit, the unused bit 0 of the enable and force registers, and the top unused data bits within reach of directed writes. The scenarios cover the pulse-to-global-bit hand-off and its cycle timing. They also cover the blocking of further pulses while the global bit is set, enabling a flag after it has already latched, a partial clear that leaves an enabled flag pending, forced flags, and an event that collides with its own clear.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
  localparam int unsigned EVT_NUM_DEF = 11;
  localparam int unsigned REG_DW_DEF  = 16;
  localparam int unsigned REG_AW      = 2;

  // Register addresses of the software port
  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE = 2'd0,
    RA_FLAGS  = 2'd1,
    RA_CLEAR  = 2'd2,
    RA_FORCE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evt_reg_port.sv
`timescale 1ns/1ps
// Register port: enable mask storage, clear/force command decode, read mux.
module evt_reg_port
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = EVT_NUM_DEF,
  parameter int unsigned DATA_W  = REG_DW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_EVT-1:0] flag_q,
  input  logic              gint_q,
  output logic [NUM_EVT-1:0] en_q,
  output logic [NUM_EVT-1:0] clr_evt,
  output logic              clr_gint,
  output logic [NUM_EVT-1:0] frc_evt,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned EVT_LSB = 1;
  localparam int unsigned EVT_MSB = NUM_EVT;

  reg_addr_e         addr_e;
  logic              en_we;
  logic [NUM_EVT-1:0] en_d;

  assign addr_e = reg_addr_e'(addr);

  // Write decode
  always_comb begin
    en_we    = wr_en && (addr_e == RA_ENABLE);
    en_d     = wdata[EVT_MSB:EVT_LSB];
    clr_evt  = '0;
    clr_gint = 1'b0;
    frc_evt  = '0;
    if (wr_en && (addr_e == RA_CLEAR)) begin
      clr_evt  = wdata[EVT_MSB:EVT_LSB];
      clr_gint = wdata[0];
    end
    if (wr_en && (addr_e == RA_FORCE)) begin
      frc_evt = wdata[EVT_MSB:EVT_LSB];
    end
  end

  // Enable mask register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (addr_e)
      RA_ENABLE: rdata[EVT_MSB:EVT_LSB] = en_q;
      RA_FLAGS: begin
        rdata[0]               = gint_q;
        rdata[EVT_MSB:EVT_LSB] = flag_q;
      end
      default: rdata = '0;
    endcase
  end

  // R3: the mask follows the written event bits on the next edge
  p_enable_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(wdata[EVT_MSB:EVT_LSB])));
endmodule

// File: rtl/evt_flag_bank.sv
`timescale 1ns/1ps
// One sticky flag per event; set by event or force, cleared by write-one.
module evt_flag_bank #(
  parameter int unsigned NUM_EVT = evt_irq_pkg::EVT_NUM_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] clr,
  input  logic [NUM_EVT-1:0] frc,
  output logic [NUM_EVT-1:0] flag_q
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cell
    logic set_c;
    logic flag_d;

    // Set has priority over clear (R10)
    always_comb begin
      set_c  = evt[g] | frc[g];
      flag_d = set_c | (flag_q[g] & ~clr[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= flag_d;
      end
    end

    p_evt_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flag_q[g]);
    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr[g]) |=> flag_q[g]);
    p_force_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frc[g] |=> flag_q[g]);
    p_clear_wins_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !evt[g] && !frc[g]) |=> !flag_q[g]);
  end
endmodule

// File: rtl/evt_irq_issue.sv
`timescale 1ns/1ps
// Global pending bit and single-cycle interrupt pulse generation.
module evt_irq_issue #(
  parameter int unsigned NUM_EVT = evt_irq_pkg::EVT_NUM_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] flag_q,
  input  logic [NUM_EVT-1:0] en_q,
  input  logic               clr_gint,
  output logic               gint_q,
  output logic               pulse_q
);
  logic any_armed;
  logic fire;
  logic gint_d;

  always_comb begin
    any_armed = |(flag_q & en_q);
    fire      = any_armed & ~gint_q;
    gint_d    = fire | (gint_q & ~clr_gint);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gint_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      gint_q  <= gint_d;
      pulse_q <= fire;
    end
  end

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_pulse_with_gint_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> gint_q);
endmodule

// File: rtl/evt_irq_gate.sv
`timescale 1ns/1ps
// Top: event flag latching, enable gating and gated interrupt pulse.
module evt_irq_gate
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = EVT_NUM_DEF,
  parameter int unsigned DATA_W  = REG_DW_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_EVT-1:0] flags_o,
  output logic               gint_o,
  output logic               irq_pulse_o
);
  logic [NUM_EVT-1:0] en_q;
  logic [NUM_EVT-1:0] clr_evt;
  logic [NUM_EVT-1:0] frc_evt;
  logic               clr_gint;

  evt_reg_port #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .flag_q  (flags_o),
    .gint_q  (gint_o),
    .en_q    (en_q),
    .clr_evt (clr_evt),
    .clr_gint(clr_gint),
    .frc_evt (frc_evt),
    .rdata   (rdata)
  );

  evt_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_i),
    .clr   (clr_evt),
    .frc   (frc_evt),
    .flag_q(flags_o)
  );

  evt_irq_issue #(.NUM_EVT(NUM_EVT)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_q  (flags_o),
    .en_q    (en_q),
    .clr_gint(clr_gint),
    .gint_q  (gint_o),
    .pulse_q (irq_pulse_o)
  );

  p_pulse_needs_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> $past(|(flags_o & en_q)));
  p_no_pulse_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gint_o && !clr_gint) |=> !irq_pulse_o);
  p_gint_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gint_o && !clr_gint) |=> gint_o);
endmodule

// File: tb/test_evt_irq_gate.sv
`timescale 1ns/1ps
module test_evt_irq_gate;
  localparam int unsigned NE = 11;
  localparam int unsigned DW = 16;

  logic          clk;
  logic          rst_n;
  logic [NE-1:0] evt_i;
  logic          wr_en;
  logic [1:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NE-1:0] flags_o;
  logic          gint_o;
  logic          irq_pulse_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  evt_irq_gate #(.NUM_EVT(NE), .DATA_W(DW)) i_evt_irq_gate (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .flags_o(flags_o), .gint_o(gint_o),
    .irq_pulse_o(irq_pulse_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one edge; drive and sample 1 ns after it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
    addr = 2'd0;
  endtask

  task automatic fire(input int idx);
    evt_i = '0;
    evt_i[idx] = 1'b1;
    tick();
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 flags", DW'(flags_o), '0);
    chk("R1 gint", DW'(gint_o), '0);
    chk("R1 pulse", DW'(irq_pulse_o), '0);
    rd(2'd0, v);
    chk("R1 enable", v, '0);
  endtask

  task automatic t_latch_disabled();
    logic [DW-1:0] v;
    fire(3);
    chk("R2 flag set", DW'(flags_o), DW'(1 << 3));
    for (int k = 0; k < 3; k++) begin
      chk("R5 no pulse", DW'(irq_pulse_o), '0);
      tick();
    end
    chk("R5 gint low", DW'(gint_o), '0);
    rd(2'd1, v);
    chk("R11 flag read", v, 16'h0010);
    rd(2'd2, v);
    chk("R11 clear addr reads zero", v, '0);
    rd(2'd3, v);
    chk("R11 force addr reads zero", v, '0);
  endtask

  task automatic t_enable_late();
    logic [DW-1:0] v;
    wr(2'd0, 16'h0011);
    rd(2'd0, v);
    chk("R3 enable read, bit0 zero", v, 16'h0010);
    chk("R12 no pulse yet", DW'(irq_pulse_o), '0);
    tick();
    chk("R12 pulse", DW'(irq_pulse_o), 16'd1);
    chk("R4 gint with pulse", DW'(gint_o), 16'd1);
    tick();
    chk("R4 pulse one cycle", DW'(irq_pulse_o), '0);
    chk("R4 gint held", DW'(gint_o), 16'd1);
    rd(2'd1, v);
    chk("R11 flags with gint", v, 16'h0011);
  endtask

  task automatic t_gint_blocks();
    wr(2'd0, 16'h0050);
    fire(5);
    chk("R6 event latches while blocked", DW'(flags_o), DW'((1 << 3) | (1 << 5)));
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R6 no pulse while gint", DW'(irq_pulse_o), '0);
    end
  endtask

  task automatic t_clear();
    wr(2'd2, 16'h0001);
    chk("R7 gint cleared", DW'(gint_o), '0);
    chk("R7 flags untouched", DW'(flags_o), DW'((1 << 3) | (1 << 5)));
    tick();
    chk("R8 pulse with pending flag", DW'(irq_pulse_o), 16'd1);
    tick();
    wr(2'd2, 16'h0011);
    chk("R7 partial clear", DW'(flags_o), DW'(1 << 5));
    tick();
    chk("R8 pulse for remaining flag", DW'(irq_pulse_o), 16'd1);
    tick();
    wr(2'd2, 16'h0041);
    chk("R7 all cleared", DW'(flags_o), '0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 quiet after full clear", DW'(irq_pulse_o), '0);
    end
    fire(3);
    chk("R8 no pulse same edge", DW'(irq_pulse_o), '0);
    tick();
    chk("R8 new event pulse", DW'(irq_pulse_o), 16'd1);
    tick();
  endtask

  task automatic t_force();
    logic [DW-1:0] v;
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hFFFF);
    chk("R7 wipe", DW'(flags_o), '0);
    chk("R7 gint wiped", DW'(gint_o), '0);
    wr(2'd3, 16'h0003);
    chk("R9 forced flag", DW'(flags_o), 16'd1);
    chk("R9 bit0 ignored", DW'(gint_o), '0);
    rd(2'd1, v);
    chk("R9 read after force", v, 16'h0002);
  endtask

  task automatic t_coincide();
    wr(2'd3, 16'h0004);
    chk("R9 force event1", DW'(flags_o), 16'h0003);
    evt_i = '0; evt_i[1] = 1'b1;
    wr(2'd2, 16'h0004);
    evt_i = '0;
    chk("R10 event beats clear", DW'(flags_o), 16'h0003);
    wr(2'd2, 16'h0004);
    chk("R7 clear alone", DW'(flags_o), 16'h0001);
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_latch_disabled();
    t_enable_late();
    t_gint_blocks();
    t_clear();
    t_force();
    t_coincide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule